// File: doc/BRIEF.md
# Multiple-Match Start Address Reporter

This block sits behind a signature matcher. While a packet streams through, the matcher hands it one bit per byte position: a set bit says that some signature ended at that position. The block collects these bits in a position buffer, one bit per position, and accumulates them across as many load beats as the packet needs. When the packet is done, the controller raises the output enable. From then on the block reports one matched position per cycle, lowest position first, as an encoded address with a valid strobe.

After the last pending position has been reported, the block raises a finish flag. A packet with M matches therefore drains in M+1 enabled cycles. Positions are converted to start offsets when they enter the buffer, by subtracting a fixed signature length constant.

Selection uses a binary tree of two-input cells. Each cell passes up an any-pending bit and contributes the address bit for its tree level, with the lower half taking priority. The reported bit is cleared on the same clock edge, so the next cycle presents the next-lowest pending position. A buffer clear empties the block before each packet.

Top module: `mar_reporter`

## Requirements
- R1: After reset, and in the cycle after `buf_clr` is high, `addr_vld_o` and `finish_o` are 0 and the buffer is empty. A following enabled cycle therefore yields `finish_o` with no address.
- R2: Each cycle with `buf_load` high ORs the shifted `load_vec` into the buffer. Bits from several loads accumulate. A position loaded more than once is reported only once.
- R3: `load_vec` bit p with p >= START_OFS is stored and reported as address p - START_OFS. Bits below START_OFS are discarded.
- R4: When several positions are pending, the lowest address is reported first, so a drain produces strictly ascending addresses.
- R5: In each cycle with `out_en` high and the buffer not empty, exactly one address is taken and its bit is cleared. It appears on `addr_o` with `addr_vld_o` high in the following cycle.
- R6: In each cycle with `out_en` high and the buffer empty, `finish_o` is high in the following cycle. A packet with M pending positions gives M valid cycles followed by `finish_o` on the cycle after them (M+1 cycles in all).
- R7: While `out_en` is low, `addr_vld_o` and `finish_o` are 0 in the following cycle and no pending position is lost.
- R8: `addr_vld_o` and `finish_o` are never high in the same cycle.
- R9: `buf_clr` takes priority over `buf_load` and over draining in the same cycle: the buffer ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_clr | input | 1 | Empty the position buffer before a packet |
| buf_load | input | 1 | OR `load_vec` into the buffer this cycle |
| load_vec | input | NPOS | Per-beat match end positions |
| out_en | input | 1 | Allow address reporting this cycle |
| addr_o | output | AW | Reported start address (AW = log2 NPOS) |
| addr_vld_o | output | 1 | `addr_o` holds a reported address |
| finish_o | output | 1 | Buffer found empty while enabled |

## Verification
The assertions check, on every cycle, the following:
- a reported address was pending in the previous cycle and no lower one was;
- finish only follows an empty buffer;
- valid and finish never coincide;
- a disabled cycle yields neither;
- clear and load leave the buffer in the right state;
- the tree always grants a pending request.

Only the bench scenarios can show the following:
- the exact address sequence for a given set of loads;
- the start-offset shift and the discarding of low bits;
- the collapse of duplicate loads;
- the M+1 cycle count;
- pausing in the middle of a drain;
- clear-versus-load priority.

These are compared against a behavioural model on every clock.

// File: rtl/mar_pkg.sv
package mar_pkg;

  // Kind of result the output register will present next cycle.
  typedef enum logic [1:0] {
    RPT_IDLE = 2'd0,
    RPT_ADDR = 2'd1,
    RPT_DONE = 2'd2
  } rpt_kind_e;

  localparam int unsigned DEF_NPOS      = 16;
  localparam int unsigned DEF_START_OFS = 3;

endpackage

// File: rtl/mar_pri_node.sv
// Two-input cell of the priority tree: lower child wins, selection adds one address bit.
module mar_pri_node #(
  parameter int unsigned AW  = 4,
  parameter int unsigned BIT = 0
) (
  input  logic          lo_any_i,
  input  logic          hi_any_i,
  input  logic [AW-1:0] lo_adr_i,
  input  logic [AW-1:0] hi_adr_i,
  output logic          any_o,
  output logic [AW-1:0] adr_o
);
  localparam logic [AW-1:0] BITMASK = AW'(1) << BIT;

  logic take_hi;

  always_comb begin
    take_hi = hi_any_i & ~lo_any_i;
    any_o   = lo_any_i | hi_any_i;
    adr_o   = take_hi ? (hi_adr_i | BITMASK) : lo_adr_i;
  end
endmodule

// File: rtl/mar_pri_tree.sv
// Heap-indexed binary tree: leaves at NPOS..2*NPOS-1, root at 1.
module mar_pri_tree #(
  parameter int unsigned NPOS = 16,
  localparam int unsigned AW  = $clog2(NPOS)
) (
  input  logic [NPOS-1:0] req_i,
  output logic            any_o,
  output logic [AW-1:0]   idx_o
);
  logic          any_h [1:2*NPOS-1];
  logic [AW-1:0] adr_h [1:2*NPOS-1];

  for (genvar k = 0; k < NPOS; k++) begin : g_leaf
    assign any_h[NPOS+k] = req_i[k];
    assign adr_h[NPOS+k] = '0;
  end

  for (genvar i = 1; i < NPOS; i++) begin : g_node
    localparam int unsigned DEPTH = $clog2(i + 1) - 1;
    mar_pri_node #(.AW(AW), .BIT(AW - 1 - DEPTH)) u_node (
      .lo_any_i (any_h[2*i]),
      .hi_any_i (any_h[2*i+1]),
      .lo_adr_i (adr_h[2*i]),
      .hi_adr_i (adr_h[2*i+1]),
      .any_o    (any_h[i]),
      .adr_o    (adr_h[i])
    );
  end

  assign any_o = any_h[1];
  assign idx_o = adr_h[1];

  // R4: a grant always points at a pending request, and nothing lower is pending.
  always_comb begin
    if (any_o) begin
      assert_grant_pending_R4: assert (req_i[idx_o]);
      assert_grant_lowest_R4: assert ((req_i & ((NPOS'(1) << idx_o) - NPOS'(1))) == '0);
    end
  end
endmodule

// File: rtl/mar_pos_buf.sv
// One bit per start position; load ORs in shifted end positions, drop clears reported bits.
module mar_pos_buf #(
  parameter int unsigned NPOS      = 16,
  parameter int unsigned START_OFS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [NPOS-1:0] load_vec_i,
  input  logic [NPOS-1:0] drop_i,
  output logic [NPOS-1:0] occ_o
);
  logic [NPOS-1:0] shifted;
  logic [NPOS-1:0] occ_q;

  // End position p becomes start offset p - START_OFS; lower bits fall off.
  assign shifted = load_vec_i >> START_OFS;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      occ_q <= '0;
    end else begin
      occ_q <= (occ_q & ~drop_i) | (load_i ? shifted : '0);
    end
  end

  assign occ_o = occ_q;

  // R9 / R1: clear empties the buffer regardless of load.
  assert_clr_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (occ_o == '0));

  // R2: loaded positions are present next cycle.
  assert_load_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clr_i) |=> ((occ_o & $past(shifted)) == $past(shifted)));

  // R5: a dropped bit is gone next cycle unless it was reloaded.
  assert_drop_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && ((drop_i & (load_i ? shifted : '0)) == '0)) |=>
      ((occ_o & $past(drop_i)) == '0));
endmodule

// File: rtl/mar_reporter.sv
module mar_reporter
  import mar_pkg::*;
#(
  parameter int unsigned NPOS      = DEF_NPOS,
  parameter int unsigned START_OFS = DEF_START_OFS,
  localparam int unsigned AW       = $clog2(NPOS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            buf_clr,
  input  logic            buf_load,
  input  logic [NPOS-1:0] load_vec,
  input  logic            out_en,
  output logic [AW-1:0]   addr_o,
  output logic            addr_vld_o,
  output logic            finish_o
);
  logic [NPOS-1:0] occ;
  logic [NPOS-1:0] drop;
  logic            any_pend;
  logic [AW-1:0]   sel_idx;
  rpt_kind_e       kind_nx;

  mar_pos_buf #(.NPOS(NPOS), .START_OFS(START_OFS)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (buf_clr),
    .load_i     (buf_load),
    .load_vec_i (load_vec),
    .drop_i     (drop),
    .occ_o      (occ)
  );

  mar_pri_tree #(.NPOS(NPOS)) u_tree (
    .req_i (occ),
    .any_o (any_pend),
    .idx_o (sel_idx)
  );

  always_comb begin
    if (!out_en)       kind_nx = RPT_IDLE;
    else if (any_pend) kind_nx = RPT_ADDR;
    else               kind_nx = RPT_DONE;
    drop = (kind_nx == RPT_ADDR) ? (NPOS'(1) << sel_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || buf_clr) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
      finish_o   <= 1'b0;
    end else begin
      addr_vld_o <= (kind_nx == RPT_ADDR);
      finish_o   <= (kind_nx == RPT_DONE);
      if (kind_nx == RPT_ADDR) addr_o <= sel_idx;
    end
  end

  // Previous-cycle buffer image, used only by the assertions below.
  logic [NPOS-1:0] occ_prev;
  always_ff @(posedge clk) begin
    if (rst) occ_prev <= '0;
    else     occ_prev <= occ;
  end

  assert_vld_was_pending_R5: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o |-> occ_prev[addr_o]);

  assert_vld_is_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o |-> ((occ_prev & ((NPOS'(1) << addr_o) - NPOS'(1))) == '0));

  assert_fin_after_empty_R6: assert property (@(posedge clk) disable iff (rst)
    finish_o |-> (occ_prev == '0));

  assert_no_vld_and_fin_R8: assert property (@(posedge clk) disable iff (rst)
    !(addr_vld_o && finish_o));

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (!addr_vld_o && !finish_o));
endmodule

// File: tb/tb_mar_reporter.sv
module tb_mar_reporter;
  localparam int NPOS = 16;
  localparam int OFS  = 3;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic            buf_clr, buf_load, out_en;
  logic [NPOS-1:0] load_vec;
  logic [AW-1:0]   addr_o;
  logic            addr_vld_o, finish_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [NPOS-1:0] mbuf;
  logic            ev, ef;
  int              ea;
  int              vld_seen;

  always #10 clk = ~clk;

  mar_reporter #(.NPOS(NPOS), .START_OFS(OFS)) dut (
    .clk(clk), .rst(rst), .buf_clr(buf_clr), .buf_load(buf_load),
    .load_vec(load_vec), .out_en(out_en),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .finish_o(finish_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(input bit c, input bit l, input logic [NPOS-1:0] v,
                     input bit e, input string tag);
    logic [NPOS-1:0] nb;
    bit found;
    buf_clr = c; buf_load = l; load_vec = v; out_en = e;
    nb = mbuf; found = 0;
    if (c) begin
      nb = '0; ev = 0; ef = 0;
    end else begin
      if (e) begin
        for (int k = 0; k < NPOS; k++) begin
          if (!found && nb[k]) begin found = 1; ea = k; nb[k] = 1'b0; end
        end
      end
      ev = e && found;
      ef = e && !found;
      if (l) nb = nb | (v >> OFS);
    end
    mbuf = nb;
    @(posedge clk);
    @(negedge clk);
    check(addr_vld_o == ev, {tag, " valid"}, addr_vld_o, ev);
    check(finish_o == ef,   {tag, " finish"}, finish_o, ef);
    if (ev) check(addr_o == ea[AW-1:0], {tag, " addr"}, addr_o, ea);
    if (addr_vld_o) vld_seen++;
  endtask

  // R6: drain until finish; M valid cycles then finish, M+1 cycles in all.
  task automatic drain(input int m, input string tag);
    int n = 0;
    vld_seen = 0;
    while (n < 40) begin
      cyc(0, 0, '0, 1, tag);
      n++;
      if (finish_o) break;
    end
    check(vld_seen == m, "R6 valid count", vld_seen, m);
    check(n == m + 1,    "R6 drain cycles", n, m + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mbuf = '0; ev = 0; ef = 0; ea = 0; vld_seen = 0;
    rst = 1; buf_clr = 0; buf_load = 0; out_en = 0; load_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(addr_vld_o == 0, "R1 reset valid", addr_vld_o, 0);
    check(finish_o == 0,   "R1 reset finish", finish_o, 0);
    rst = 0;

    // R1 / R6: empty buffer finishes on the first enabled cycle.
    cyc(1, 0, '0, 0, "R1 clear");
    drain(0, "R6 empty");

    // R3 / R4: end positions 3,5,9 -> start addresses 0,2,6 in order.
    cyc(1, 0, '0, 0, "R1 clear");
    cyc(0, 1, 16'h0228, 0, "R3 load");
    cyc(0, 0, '0, 1, "R4 first");
    check(addr_o == 0, "R3 offset first addr", addr_o, 0);
    cyc(0, 0, '0, 1, "R4 second");
    check(addr_o == 2, "R4 second addr", addr_o, 2);
    drain(1, "R4 rest");

    // R3: bits below the offset are discarded.
    cyc(1, 0, '0, 0, "R1 clear");
    cyc(0, 1, 16'h0007, 0, "R3 low bits");
    drain(0, "R3 low only");

    // R2: accumulation over beats and duplicate collapse.
    cyc(1, 0, '0, 0, "R1 clear");
    cyc(0, 1, 16'h8010, 0, "R2 beat1");
    cyc(0, 1, 16'h0410, 0, "R2 beat2");
    cyc(0, 1, 16'h8000, 0, "R2 beat3");
    drain(3, "R2 drain");

    // R7: pause mid-drain, nothing lost.
    cyc(1, 0, '0, 0, "R1 clear");
    cyc(0, 1, 16'hF0F8, 0, "R7 load");
    cyc(0, 0, '0, 1, "R7 run");
    cyc(0, 0, '0, 0, "R7 pause");
    cyc(0, 0, '0, 0, "R7 pause");
    drain(8, "R7 resume");

    // R5: load during drain, new lower position enters the order.
    cyc(1, 0, '0, 0, "R1 clear");
    cyc(0, 1, 16'h4000, 0, "R5 load");
    cyc(0, 1, 16'h0010, 1, "R5 load+drain");
    drain(1, "R5 rest");

    // R9: clear beats a simultaneous load.
    cyc(0, 1, 16'hFFF8, 0, "R9 preload");
    cyc(1, 1, 16'hFFFF, 1, "R9 clr+load");
    drain(0, "R9 after");

    // Full buffer: all 13 start addresses ascending.
    cyc(1, 0, '0, 0, "R1 clear");
    cyc(0, 1, 16'hFFFF, 0, "R4 full load");
    drain(NPOS - OFS, "R4 full");

    // R1: reset mid-drain empties the buffer.
    cyc(0, 1, 16'h0F00, 0, "R1 preload");
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0; mbuf = '0;
    drain(0, "R1 after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule